// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Port with In-Band Odd Parity

This block is a full-duplex asynchronous serial port. The transmitter and the receiver share one bit-rate tick, which an external counter/timer supplies at sixteen times the line bit rate. Software writes one byte to start a transmission. The transmitter frames the byte with a low start bit and two high stop bits, sends it least-significant bit first, and raises a one-cycle interrupt pulse after the last stop bit. The receiver oversamples the serial input. It confirms each start bit at mid-bit and then samples every later bit at its centre. It accepts a frame that ends with one stop bit, holds the character for reading and pulses its own interrupt.

Exactly eight bits travel on the line in every frame. With odd parity selected, the top bit position is not data. On transmit it carries a parity bit computed over the seven low data bits. On receive the top bit of the stored byte is replaced by a parity-error flag.

A global enable gates both directions. While the enable is low, the output rests at the mark (high) level, a frame in progress is dropped and the input is ignored.

Top module: `uart_duplex_core`

## Requirements
- R1: After reset, `txd` is high, `tx_irq`, `rx_irq` and `rx_ovr` are low, and `txd` stays high whenever no character is being sent.
- R2: An accepted write produces, on `txd`, one low start bit, then bits 0 to 7 of the frame byte (least-significant first), then two high stop bits. Each bit lasts exactly 16 `bit_tick` pulses, and the start bit begins on the clock edge that accepts the write.
- R3: When `par_en` is 1 at the write, frame bit 7 is the odd-parity bit over `tx_data[6:0]`: it is 1 exactly when those seven bits hold an even number of ones. Bits 6:0 are sent unchanged.
- R4: `tx_irq` is a single-cycle pulse, produced on the edge where the second stop bit ends. A `tx_wr` that arrives while a character is still being sent is ignored.
- R5: The receiver accepts a low start bit, eight bits sent least-significant first, and a single high stop bit. It then presents the byte on `rx_data` and pulses `rx_irq` for one cycle. That pulse comes about 9.5 bit times after the start edge.
- R6: When `par_en` is 1, `rx_data[6:0]` holds the received bits 6:0. `rx_data[7]` is then 1 exactly when the eight received bits contain an even number of ones, and 0 otherwise.
- R7: A low pulse on `rxd` that has returned high by the middle of the would-be start bit produces no character and no `rx_irq`.
- R8: A low level at the stop-bit sample point sets `rx_ferr` to 1 for that character, and the character is still delivered. A high stop bit gives `rx_ferr` 0.
- R9: A character completed while the previous one is unread (no `rx_rd` since it arrived) replaces it and sets `rx_ovr`. An `rx_rd` clears `rx_ovr`. An `rx_rd` in the very cycle of completion counts as reading first, so `rx_ovr` stays 0.
- R10: While `en` is 0, `txd` is high, a frame in progress is abandoned, writes are ignored, and no character is received.
- R11: A transmission and a reception can run at the same time without affecting each other's timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global serial-function enable |
| bit_tick | input | 1 | Oversampling tick, 16 per bit time |
| par_en | input | 1 | Odd parity in bit 7 when 1 |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial output, idles high |
| tx_irq | output | 1 | Pulse when a character has been sent |
| rxd | input | 1 | Serial input, asynchronous |
| rx_rd | input | 1 | Read strobe for the received byte |
| rx_data | output | 8 | Last received byte (bit 7 is the parity flag in parity mode) |
| rx_ferr | output | 1 | Stop bit sampled low for the last character |
| rx_ovr | output | 1 | Last character overwrote an unread one |
| rx_irq | output | 1 | Pulse when a character has been received |

## Verification
The interesting collision is a software read strobe landing in the same clock cycle in which the receiver finishes a new character while the previous one is still unread. The bench first measures the fixed latency from a start edge to the receive pulse. It then launches a second frame at the same tick phase and places `rx_rd` exactly on the completion cycle. The result is judged by requiring `rx_ovr` to stay 0 with the new byte presented. Separately, a transmission is started in the same cycle as an incoming frame, and the transmitter's line is compared every clock against a behavioural queue model.

// File: rtl/uart_pkg.sv
`timescale 1ns/1ps
package uart_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uart_tx_eng.sv
`timescale 1ns/1ps
module uart_tx_eng #(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 2,
  parameter int OVS       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              par_en,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              txd,
  output logic              done
);
  localparam int FRAME_W = 1 + DATA_W + STOP_BITS;
  localparam int CNT_W   = $clog2(OVS);
  localparam int IDX_W   = $clog2(FRAME_W + 1);
  localparam int STOP_AT = FRAME_W - STOP_BITS;

  logic               busy;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   tcnt;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  payload;

  // parity replaces the top data bit; odd total over the 8 bits
  always_comb begin
    payload = wdata;
    if (par_en) payload[DATA_W-1] = ~^wdata[DATA_W-2:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      done  <= 1'b0;
      tcnt  <= '0;
      idx   <= '0;
      frame <= '1;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (wr) begin
          busy  <= 1'b1;
          frame <= {{STOP_BITS{1'b1}}, payload, 1'b0};
          txd   <= 1'b0;
          tcnt  <= '0;
          idx   <= '0;
        end
      end else if (tick) begin
        if (tcnt == CNT_W'(OVS - 1)) begin
          tcnt  <= '0;
          frame <= {1'b1, frame[FRAME_W-1:1]};
          if (idx == IDX_W'(FRAME_W - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            txd  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            txd <= frame[1];
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  p_start_space_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && idx == '0) |-> !txd);
  p_stop_mark_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && idx >= IDX_W'(STOP_AT)) |-> txd);
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/uart_rx_eng.sv
`timescale 1ns/1ps
module uart_rx_eng
  import uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              par_en,
  input  logic              rxd_s,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              ferr,
  output logic              ovr,
  output logic              done
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] END = CNT_W'(OVS - 1);

  rx_state_t         state;
  logic [CNT_W-1:0]  tcnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sh;
  logic              full;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      tcnt  <= '0;
      idx   <= '0;
      sh    <= '0;
      rdata <= '0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
      full  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rd) begin
        full <= 1'b0;
        ovr  <= 1'b0;
      end
      if (!en) begin
        state <= RX_IDLE;
      end else if (tick) begin
        case (state)
          RX_IDLE: if (!rxd_s) begin
            state <= RX_START;
            tcnt  <= '0;
          end
          RX_START: if (tcnt == MID) begin
            tcnt <= '0;
            idx  <= '0;
            state <= rxd_s ? RX_IDLE : RX_DATA;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
          RX_DATA: if (tcnt == END) begin
            tcnt <= '0;
            sh   <= {rxd_s, sh[DATA_W-1:1]};
            if (idx == IDX_W'(DATA_W - 1)) state <= RX_STOP;
            else idx <= idx + 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
          RX_STOP: if (tcnt == END) begin
            state <= RX_IDLE;
            tcnt  <= '0;
            done  <= 1'b1;
            ferr  <= !rxd_s;
            rdata <= par_en ? {~^sh, sh[DATA_W-2:0]} : sh;
            ovr   <= full && !rd;
            full  <= 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_glitch_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (en && tick && state == RX_START && tcnt == MID && rxd_s) |=> (state == RX_IDLE && !done));
  p_ovr_on_done_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> done);
  p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (rd && !(en && tick && state == RX_STOP && tcnt == END)) |=> !ovr);
endmodule

// File: rtl/uart_duplex_core.sv
`timescale 1ns/1ps
module uart_duplex_core #(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 2,
  parameter int OVS       = 16,
  parameter int SYNC_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              bit_tick,
  input  logic              par_en,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              txd,
  output logic              tx_irq,
  input  logic              rxd,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ferr,
  output logic              rx_ovr,
  output logic              rx_irq
);
  logic [SYNC_W-1:0] rx_sync;

  always_ff @(posedge clk) begin
    if (rst) rx_sync <= '1;
    else     rx_sync <= {rx_sync[SYNC_W-2:0], rxd};
  end

  uart_tx_eng #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .en(en), .tick(bit_tick), .par_en(par_en),
    .wr(tx_wr), .wdata(tx_data), .txd(txd), .done(tx_irq)
  );

  uart_rx_eng #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .en(en), .tick(bit_tick), .par_en(par_en),
    .rxd_s(rx_sync[SYNC_W-1]), .rd(rx_rd), .rdata(rx_data),
    .ferr(rx_ferr), .ovr(rx_ovr), .done(rx_irq)
  );

  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (txd && !tx_irq && !rx_irq));
endmodule

// File: tb/uart_duplex_core_tb.sv
`timescale 1ns/1ps
module uart_duplex_core_tb_top;
  logic clk = 0, rst = 1, en = 1, bit_tick = 0, par_en = 0;
  logic tx_wr = 0, rxd = 1, rx_rd = 0;
  logic [7:0] tx_data = 0;
  logic txd, tx_irq, rx_ferr, rx_ovr, rx_irq;
  logic [7:0] rx_data;

  int checks = 0, failures = 0;
  int cyc = 0, last_start = 0, lat = 0;
  int rx_cnt = 0, tx_cnt = 0, cyc_irq = 0;
  logic [7:0] cap_data;
  logic cap_ferr, cap_ovr;
  bit finished = 0;

  // tx reference model state
  int q[$];
  int tcnt = 0;
  logic exp_txd = 1, exp_irq = 0;

  always #2.5 clk = ~clk;

  uart_duplex_core dut_i (
    .clk(clk), .rst(rst), .en(en), .bit_tick(bit_tick), .par_en(par_en),
    .tx_wr(tx_wr), .tx_data(tx_data), .txd(txd), .tx_irq(tx_irq),
    .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data), .rx_ferr(rx_ferr),
    .rx_ovr(rx_ovr), .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) bit_tick <= ~bit_tick;

  // behavioural transmit model: R2 R3 R4 R10
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      q.delete(); exp_txd = 1; exp_irq = 0; tcnt = 0;
    end else begin
      exp_irq = 0;
      if (!en) begin
        q.delete(); exp_txd = 1;
      end else if (q.size() == 0) begin
        if (tx_wr) begin
          logic [7:0] f;
          f = tx_data;
          if (par_en) f[7] = ($countones(tx_data[6:0]) % 2 == 0);
          q.push_back(0);
          for (int i = 0; i < 8; i++) q.push_back(int'(f[i]));
          q.push_back(1); q.push_back(1);
          exp_txd = 0; tcnt = 0;
        end
      end else if (bit_tick) begin
        tcnt++;
        if (tcnt == 16) begin
          tcnt = 0;
          void'(q.pop_front());
          if (q.size() == 0) begin exp_irq = 1; exp_txd = 1; end
          else exp_txd = q[0][0];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(txd === exp_txd, "R2", "txd vs model", txd, exp_txd);
      chk(tx_irq === exp_irq, "R4", "tx_irq vs model", tx_irq, exp_irq);
      if (tx_irq) tx_cnt++;
      if (rx_irq) begin
        rx_cnt++; cap_data = rx_data; cap_ferr = rx_ferr; cap_ovr = rx_ovr;
        cyc_irq = cyc;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tx_write(input logic [7:0] d);
    @(negedge clk); tx_wr = 1; tx_data = d;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic rx_read();
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic send_rx(input logic [7:0] b, input bit bad_stop);
    @(negedge clk);
    while (bit_tick) @(negedge clk);
    last_start = cyc;
    rxd = 0; repeat (32) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (32) @(negedge clk); end
    if (bad_stop) begin rxd = 0; repeat (20) @(negedge clk); end
    rxd = 1; repeat (48) @(negedge clk);
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n0;
    wait_clks(4); rst = 0; wait_clks(2);
    // R1 reset state
    chk(txd === 1'b1, "R1", "txd idle", txd, 1);
    chk(tx_irq === 1'b0 && rx_irq === 1'b0, "R1", "irqs low", {tx_irq, rx_irq}, 0);
    chk(rx_ovr === 1'b0, "R1", "rx_ovr low", rx_ovr, 0);

    // R2 R4 plain transmit
    tx_write(8'hA5); wait_clks(370);
    chk(tx_cnt == 1, "R4", "one tx pulse", tx_cnt, 1);

    // R3 parity transmit, R4 write while busy ignored
    par_en = 1; tx_write(8'h35); wait_clks(100); tx_write(8'hFF);
    wait_clks(300); par_en = 0;
    chk(tx_cnt == 2, "R4", "busy write ignored", tx_cnt, 2);
    tx_write(8'h00); wait_clks(370);
    chk(tx_cnt == 3, "R2", "zero byte sent", tx_cnt, 3);

    // R5 receive, single stop
    n0 = rx_cnt; send_rx(8'h3C, 0);
    chk(rx_cnt == n0 + 1, "R5", "rx count", rx_cnt, n0 + 1);
    chk(cap_data == 8'h3C, "R5", "rx data", cap_data, 8'h3C);
    chk(cap_ferr == 0 && cap_ovr == 0, "R5", "rx flags clean", {cap_ferr, cap_ovr}, 0);
    lat = cyc_irq - last_start;
    chk(lat >= 300 && lat <= 330, "R5", "rx latency", lat, 310);
    rx_read();

    // R6 parity receive
    par_en = 1;
    send_rx(8'hB0, 0);
    chk(cap_data == 8'h30, "R6", "odd ones flag 0", cap_data, 8'h30); rx_read();
    send_rx(8'h33, 0);
    chk(cap_data == 8'hB3, "R6", "even ones flag 1", cap_data, 8'hB3); rx_read();
    par_en = 0;

    // R7 start glitch
    n0 = rx_cnt;
    @(negedge clk); rxd = 0; wait_clks(6); rxd = 1; wait_clks(400);
    chk(rx_cnt == n0, "R7", "glitch dropped", rx_cnt, n0);

    // R8 framing error
    n0 = rx_cnt; send_rx(8'h5A, 1); wait_clks(300);
    chk(rx_cnt == n0 + 1, "R8", "one char", rx_cnt, n0 + 1);
    chk(cap_ferr == 1, "R8", "ferr set", cap_ferr, 1);
    chk(cap_data == 8'h5A, "R8", "data kept", cap_data, 8'h5A);
    rx_read();
    send_rx(8'h5B, 0);
    chk(cap_ferr == 0, "R8", "ferr clear on good stop", cap_ferr, 0); rx_read();

    // R9 overrun
    send_rx(8'h11, 0); send_rx(8'h22, 0);
    chk(cap_ovr == 1 && cap_data == 8'h22, "R9", "overrun set", {cap_ovr, cap_data}, 9'h122);
    rx_read(); wait_clks(1);
    chk(rx_ovr == 0, "R9", "read clears ovr", rx_ovr, 0);

    // R9 read in the completion cycle
    send_rx(8'h44, 0);
    fork
      send_rx(8'h66, 0);
      begin
        int t0;
        wait (rxd == 0); t0 = last_start;
        while (cyc != t0 + lat - 1) @(negedge clk);
        rx_rd = 1; @(negedge clk); rx_rd = 0;
      end
    join
    chk(cap_ovr == 0 && cap_data == 8'h66, "R9", "same-cycle read wins", {cap_ovr, cap_data}, 9'h066);
    rx_read();

    // R10 enable low
    tx_write(8'h0F); wait_clks(100);
    @(negedge clk); en = 0; wait_clks(3);
    chk(txd === 1'b1, "R10", "txd mark while off", txd, 1);
    tx_write(8'hAA);
    n0 = rx_cnt; send_rx(8'h77, 0);
    chk(rx_cnt == n0, "R10", "no rx while off", rx_cnt, n0);
    n0 = tx_cnt;
    @(negedge clk); en = 1; wait_clks(400);
    chk(tx_cnt == n0, "R10", "aborted tx no pulse", tx_cnt, n0);

    // R11 concurrent transmit and receive
    n0 = tx_cnt;
    fork
      tx_write(8'hC3);
      send_rx(8'h7E, 0);
    join
    wait_clks(80);
    chk(cap_data == 8'h7E, "R11", "rx data during tx", cap_data, 8'h7E);
    chk(tx_cnt == n0 + 1, "R11", "tx done during rx", tx_cnt, n0 + 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule